// File: doc/BRIEF.md
# Streaming Store Line Packer

This block sits between a compute kernel that writes memory as a stream of typed elements and a memory port that only accepts whole 64-byte cache lines. The kernel first opens a burst with a header that holds a starting byte address and an element count. It then pushes the elements one per transfer on a separate data channel. The packer places each element into its slot of a line register. It emits one line write when the last slot of the line has been filled, or when the burst's final element arrives.

Lines are always written whole and never byte-masked. A burst that starts or stops partway through a line therefore writes zeros into every slot it did not fill. The block suits streaming stores. It must not be used for scattered single-element writes into lines that hold other live data, because those writes destroy that data.

Top module: `stp_store_packer`

## Requirements
- R1: After reset, hdr_ready is 1, dat_ready is 0 and wr_valid is 0.
- R2: hdr_ready is 1 exactly when no burst is open and no line write is pending. A header with hdr_count equal to zero is consumed without opening a burst and without producing a line write.
- R3: dat_ready is 0 whenever no burst is open, so data presented while idle is not taken and causes no line write.
- R4: For a burst with byte address A, with 32-bit elements and 16 slots per line, element k occupies wr_line_data bits [32*s+31:32*s], where s = ((A>>2)+k) mod 16.
- R5: Filling slot 15 raises wr_valid on the next cycle, carrying the completed line.
- R6: When the burst's last element lands in a slot below 15, the partial line is written at once, and every slot the burst did not fill reads as zero.
- R7: The first element of a burst goes to the slot given by address bits [5:2]. Lower slots of that first line are written as zero.
- R8: While wr_valid is 1 and wr_ready is 0, wr_valid, wr_line_addr and wr_line_data hold steady.
- R9: While a line write is pending (wr_valid is 1), dat_ready is 0.
- R10: wr_line_addr of a burst's first line is A>>6. Each later line of the same burst carries the previous line address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken |
| hdr_addr | input | ADDR_W (32) | Burst start byte address, element aligned |
| hdr_count | input | CNT_W (16) | Number of elements in the burst |
| dat_valid | input | 1 | Element offered |
| dat_ready | output | 1 | Element can be taken |
| dat_elem | input | ELEM_W (32) | Element value |
| wr_valid | output | 1 | Line write pending |
| wr_ready | input | 1 | Memory accepts the line write |
| wr_line_addr | output | ADDR_W-6 (26) | Line address (byte address divided by 64) |
| wr_line_data | output | 512 | Full line contents, slot 0 in the low bits |

## Verification
The assertions assume that every header address is aligned to the element size, so bits [1:0] are zero. They also assume that the kernel only counts a transfer as done when valid and ready are both high in the same cycle. The stimulus uses only element-aligned start addresses, including line-aligned ones, mid-line ones and one at the last slot. It holds each valid until it sees the matching ready. It also drives data while idle and throttles wr_ready with a seeded pseudo-random pattern, which exercises the hold and stall behaviour without breaking those assumptions.

// File: rtl/stp_pkg.sv
// Package: shared constants and types for the streaming store line packer.
// Assumes a fixed 64-byte line; element width is chosen per instance.
package stp_pkg;
    localparam int unsigned STP_LINE_BYTES = 64;

    typedef enum logic {
        BURST_IDLE = 1'b0,
        BURST_RUN  = 1'b1
    } burst_state_e;
endpackage

// File: rtl/stp_burst_ctl.sv
// Burst tracker: holds the open burst's remaining count, the current slot
// inside the line and the current line address.
// Assumes hdr_fire only while idle and elem_fire only while a burst is open.
module stp_burst_ctl
    import stp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int OFS_W    = 6,
    parameter int ELEM_OFS = 2,
    localparam int SLOT_W  = OFS_W - ELEM_OFS,
    localparam int LADDR_W = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_fire,
    input  logic [ADDR_W-1:0]  hdr_addr,
    input  logic [CNT_W-1:0]   hdr_count,
    input  logic               elem_fire,
    output logic               active,
    output logic [SLOT_W-1:0]  slot,
    output logic [LADDR_W-1:0] line_addr,
    output logic               last_elem,
    output logic               line_end
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    burst_state_e       st_q;
    logic [CNT_W-1:0]   rem_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [LADDR_W-1:0] line_q;

    // Open a burst on a header, then step slot, line and count per element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BURST_IDLE;
            rem_q  <= '0;
            slot_q <= '0;
            line_q <= '0;
        end else if (hdr_fire) begin
            st_q   <= (hdr_count != '0) ? BURST_RUN : BURST_IDLE;
            rem_q  <= hdr_count;
            slot_q <= hdr_addr[OFS_W-1:ELEM_OFS];
            line_q <= hdr_addr[ADDR_W-1:OFS_W];
        end else if (elem_fire) begin
            rem_q  <= rem_q - CNT_W'(1);
            slot_q <= slot_q + SLOT_W'(1);
            if (slot_q == SLOT_MAX) begin
                line_q <= line_q + LADDR_W'(1);
            end
            if (rem_q == CNT_W'(1)) begin
                st_q <= BURST_IDLE;
            end
        end
    end

    // Expose tracker state to the packer.
    always_comb begin
        active    = (st_q == BURST_RUN);
        slot      = slot_q;
        line_addr = line_q;
        last_elem = (rem_q == CNT_W'(1));
        line_end  = (slot_q == SLOT_MAX);
    end

    // R2: an open burst always has elements left to take.
    a_r2_open_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rem_q != '0));

    // R3: elements are only consumed while a burst is open.
    a_r3_elem_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
        elem_fire |-> active);
endmodule

// File: rtl/stp_line_buf.sv
// Line register and write port: one lane per element slot, presented whole
// on the memory side and cleared to zero once the write is accepted.
// Assumes elem_fire never coincides with a pending write.
module stp_line_buf #(
    parameter int ELEM_W   = 32,
    parameter int LINE_W   = 512,
    parameter int SLOT_W   = 4,
    parameter int LADDR_W  = 26,
    localparam int EPL     = LINE_W / ELEM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               elem_fire,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [ELEM_W-1:0]  elem,
    input  logic               flush,
    input  logic [LADDR_W-1:0] line_addr,
    input  logic               wr_ready,
    output logic               wr_valid,
    output logic [LADDR_W-1:0] wr_line_addr,
    output logic [LINE_W-1:0]  wr_line_data
);
    logic drain;
    logic valid_q;
    logic [LADDR_W-1:0] addr_q;

    assign drain = valid_q & wr_ready;

    for (genvar g = 0; g < EPL; g++) begin : g_lane
        logic [ELEM_W-1:0] lane_q;

        // Capture the element addressed to this slot; zero after the write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (elem_fire && (slot == SLOT_W'(g))) begin
                lane_q <= elem;
            end else if (drain) begin
                lane_q <= '0;
            end
        end

        assign wr_line_data[g*ELEM_W +: ELEM_W] = lane_q;
    end

    // Raise the write on a flush and hold it until memory takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (flush) begin
            valid_q <= 1'b1;
            addr_q  <= line_addr;
        end else if (drain) begin
            valid_q <= 1'b0;
        end
    end

    assign wr_valid     = valid_q;
    assign wr_line_addr = addr_q;

    // R8: a stalled write keeps its valid, address and data.
    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_line_addr) && $stable(wr_line_data)));

    // R9: no element lands in the line while its write is pending.
    a_r9_no_fill_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !elem_fire);
endmodule

// File: rtl/stp_store_packer.sv
// Streaming store line packer: takes a burst header and then a stream of
// elements, gathers them into 64-byte lines and writes each line whole.
// Assumes element-aligned header addresses and an element width that is a
// power-of-two number of bytes smaller than a line.
module stp_store_packer
    import stp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ELEM_W   = 32,
    parameter int CNT_W    = 16,
    localparam int LINE_W  = STP_LINE_BYTES * 8,
    localparam int OFS_W   = $clog2(STP_LINE_BYTES),
    localparam int ELEM_OFS = $clog2(ELEM_W / 8),
    localparam int SLOT_W  = OFS_W - ELEM_OFS,
    localparam int LADDR_W = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    output logic               hdr_ready,
    input  logic [ADDR_W-1:0]  hdr_addr,
    input  logic [CNT_W-1:0]   hdr_count,
    input  logic               dat_valid,
    output logic               dat_ready,
    input  logic [ELEM_W-1:0]  dat_elem,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [LADDR_W-1:0] wr_line_addr,
    output logic [LINE_W-1:0]  wr_line_data
);
    logic               active;
    logic [SLOT_W-1:0]  slot;
    logic [LADDR_W-1:0] line_addr;
    logic               last_elem;
    logic               line_end;
    logic               hdr_fire;
    logic               elem_fire;
    logic               flush;

    // Handshake gating: headers only when idle, data only into a free line.
    always_comb begin
        hdr_ready = !active && !wr_valid;
        dat_ready = active && !wr_valid;
        hdr_fire  = hdr_valid && hdr_ready;
        elem_fire = dat_valid && dat_ready;
        flush     = elem_fire && (line_end || last_elem);
    end

    stp_burst_ctl #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .OFS_W    (OFS_W),
        .ELEM_OFS (ELEM_OFS)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_fire  (hdr_fire),
        .hdr_addr  (hdr_addr),
        .hdr_count (hdr_count),
        .elem_fire (elem_fire),
        .active    (active),
        .slot      (slot),
        .line_addr (line_addr),
        .last_elem (last_elem),
        .line_end  (line_end)
    );

    stp_line_buf #(
        .ELEM_W  (ELEM_W),
        .LINE_W  (LINE_W),
        .SLOT_W  (SLOT_W),
        .LADDR_W (LADDR_W)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .elem_fire    (elem_fire),
        .slot         (slot),
        .elem         (dat_elem),
        .flush        (flush),
        .line_addr    (line_addr),
        .wr_ready     (wr_ready),
        .wr_valid     (wr_valid),
        .wr_line_addr (wr_line_addr),
        .wr_line_data (wr_line_data)
    );

    // R2: header and data channels are never ready together.
    a_r2_channels_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |-> !dat_ready);

    // R6: an accepted write leaves the port idle for at least one cycle.
    a_r6_write_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_valid);

    if (ELEM_OFS > 0) begin : g_align_chk
        // R7: header addresses are element aligned (input assumption).
        a_r7_hdr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            hdr_fire |-> (hdr_addr[ELEM_OFS-1:0] == '0));
    end
endmodule

// File: tb/tb_stp_store_packer.sv
// Bench: behavioural model of bursts and line writes, compared every cycle.
module tb_stp_store_packer;
    localparam int ADDR_W  = 32;
    localparam int ELEM_W  = 32;
    localparam int CNT_W   = 16;
    localparam int LINE_W  = 512;
    localparam int EPL     = 16;
    localparam int LADDR_W = 26;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               hdr_valid = 1'b0;
    logic               hdr_ready;
    logic [ADDR_W-1:0]  hdr_addr = '0;
    logic [CNT_W-1:0]   hdr_count = '0;
    logic               dat_valid = 1'b0;
    logic               dat_ready;
    logic [ELEM_W-1:0]  dat_elem = '0;
    logic               wr_valid;
    logic               wr_ready = 1'b1;
    logic [LADDR_W-1:0] wr_line_addr;
    logic [LINE_W-1:0]  wr_line_data;

    int total = 0;
    int bad = 0;
    int writes_seen = 0;
    bit throttle = 1'b0;

    // Reference model state
    bit                 m_active;
    bit                 m_pend;
    int                 m_rem;
    int                 m_slot;
    logic [LADDR_W-1:0] m_line;
    logic [LADDR_W-1:0] m_paddr;
    logic [ELEM_W-1:0]  m_buf [EPL];
    logic [LINE_W-1:0]  m_pdata;

    always #2 clk = ~clk;

    stp_store_packer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_valid    (hdr_valid),
        .hdr_ready    (hdr_ready),
        .hdr_addr     (hdr_addr),
        .hdr_count    (hdr_count),
        .dat_valid    (dat_valid),
        .dat_ready    (dat_ready),
        .dat_elem     (dat_elem),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_line_addr (wr_line_addr),
        .wr_line_data (wr_line_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare outputs with the model, then advance the model past the edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_pend = 0; m_rem = 0; m_slot = 0;
            m_line = '0; m_paddr = '0; m_pdata = '0;
            for (int i = 0; i < EPL; i++) m_buf[i] = '0;
        end else begin
            bit exp_hr, exp_dr, hf, df, wf;
            exp_hr = !m_active && !m_pend;
            exp_dr = m_active && !m_pend;
            check(hdr_ready === exp_hr, "R2", "hdr_ready", LINE_W'(hdr_ready), LINE_W'(exp_hr));
            check(dat_ready === exp_dr, m_pend ? "R9" : "R3", "dat_ready",
                  LINE_W'(dat_ready), LINE_W'(exp_dr));
            check(wr_valid === m_pend, "R5/R6", "wr_valid", LINE_W'(wr_valid), LINE_W'(m_pend));
            if (m_pend) begin
                check(wr_line_addr === m_paddr, "R10", "wr_line_addr",
                      LINE_W'(wr_line_addr), LINE_W'(m_paddr));
                check(wr_line_data === m_pdata, "R4/R7/R8", "wr_line_data",
                      wr_line_data, m_pdata);
            end
            hf = hdr_valid && exp_hr;
            df = dat_valid && exp_dr;
            wf = m_pend && wr_ready;
            if (wf) begin
                m_pend = 0;
                writes_seen++;
            end
            if (hf && hdr_count != 0) begin
                m_active = 1;
                m_rem    = int'(hdr_count);
                m_slot   = int'(hdr_addr[5:2]);
                m_line   = hdr_addr[31:6];
            end
            if (df) begin
                m_buf[m_slot] = dat_elem;
                m_rem--;
                if (m_slot == EPL - 1 || m_rem == 0) begin
                    m_pend  = 1;
                    m_paddr = m_line;
                    for (int i = 0; i < EPL; i++) begin
                        m_pdata[i*ELEM_W +: ELEM_W] = m_buf[i];
                        m_buf[i] = '0;
                    end
                    if (m_rem == 0) m_active = 0;
                end
                if (m_slot == EPL - 1) m_line = m_line + 1'b1;
                m_slot = (m_slot + 1) % EPL;
            end
        end
    end

    // Memory-side ready: always high, or throttled by a seeded pattern.
    initial begin
        void'($urandom(7));
        forever begin
            @(posedge clk); #1;
            wr_ready = throttle ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    task automatic run_burst(input logic [31:0] addr, input int count,
                             input logic [31:0] base, input bit gaps);
        @(posedge clk); #1;
        hdr_valid = 1'b1; hdr_addr = addr; hdr_count = CNT_W'(count);
        do @(negedge clk); while (!hdr_ready);
        @(posedge clk); #1;
        hdr_valid = 1'b0;
        for (int k = 0; k < count; k++) begin
            dat_valid = 1'b1;
            dat_elem  = base + 32'(k);
            do @(negedge clk); while (!dat_ready);
            @(posedge clk); #1;
            dat_valid = 1'b0;
            if (gaps && (k % 3 == 0)) begin
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(hdr_ready === 1'b1, "R1", "hdr_ready after reset", LINE_W'(hdr_ready), 1);
        check(dat_ready === 1'b0, "R1", "dat_ready after reset", LINE_W'(dat_ready), 0);
        check(wr_valid === 1'b0, "R1", "wr_valid after reset", LINE_W'(wr_valid), 0);
        // R3: data while idle is refused and writes nothing
        @(posedge clk); #1;
        dat_valid = 1'b1; dat_elem = 32'hDEAD_BEEF;
        repeat (4) begin @(posedge clk); #1; end
        dat_valid = 1'b0;
        @(negedge clk);
        check(wr_valid === 1'b0, "R3", "no write from idle data", LINE_W'(wr_valid), 0);
        run_burst(32'h0000_1000, 16, 32'h1000_0000, 1'b0); // R5 full aligned line
        run_burst(32'h0000_2000, 5,  32'h2000_0000, 1'b0); // R6 partial line
        run_burst(32'h0000_301C, 20, 32'h3000_0000, 1'b0); // R7 and R10 mid-line start
        run_burst(32'h0000_4000, 0,  32'h4000_0000, 1'b0); // R2 empty burst
        run_burst(32'h0000_503C, 1,  32'h5000_0000, 1'b0); // R7 last slot only
        throttle = 1'b1;                                   // R8 and R9 under stall
        run_burst(32'h0000_6008, 40, 32'h6000_0000, 1'b1);
        run_burst(32'h0000_7000, 33, 32'h7000_0000, 1'b0);
        throttle = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        // R10: line count across all bursts (1+1+2+0+1+3+3)
        check(writes_seen == 11, "R10", "line writes issued", LINE_W'(writes_seen), 11);
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete");
        summary();
        $finish;
    end
endmodule